// File: doc/BRIEF.md
# Banked Interrupt Controller

The block gathers up to 81 interrupt sources into two request lines for one processor: a normal request (`irq_o`) and a fast request (`fiq_o`). The sources are held in three banks of 32 bits. Per source, software programs an enable bit, a separate mask bit and a route bit that picks the output line. Every bank register is reached through a plain 32-bit register port with a byte address. A read-only vector register turns the lowest-numbered eligible normal source into an address, so dispatch software can jump straight to it.

Sources 1 to 80 are level inputs. Their pending bits follow the sampled input and ignore writes. Source 0 is an external non-maskable event input. It has a latched pending bit, a two-bit trigger-type field and a write-one-to-clear action. A base-address register and a one-bit protection register are also provided, and software can read back and write both of them.

Top module: `banked_intc`

## Requirements
- R1: After reset every enable bit is 0, every mask bit of a valid source is 1 (bank 2 masks read 0x0001FFFF), every pending bit is 0, both outputs are 0 and the vector reads 0.
- R2: Source n sits at bit n%32 of bank n/32. The register groups are at byte offsets 0x10 (normal pending), 0x20 (fast pending), 0x30 (route), 0x40 (enable) and 0x50 (mask), with 4 bytes per bank. Enable, mask and route read back what was written.
- R3: Bits for source numbers 81 and above always read 0 and cannot be set.
- R4: For sources other than 0, the pending bit is the input sampled on the previous clock edge ANDed with the enable bit. Writes to the pending registers do not change these bits.
- R5: A source drives an output only when it is pending, enabled and not masked. Masking does not clear a pending bit.
- R6: An output rises on the first clock edge after an enabled, unmasked source input rises, and not before that edge.
- R7: The vector register (offset 0x00) reads the base (offset 0x04) plus 4 times the lowest-numbered pending, enabled, unmasked source that is routed to `irq_o`. It reads the base alone when there is no such source.
- R8: The pending bit of source 0 is latched. Writing a word with bit 0 set to offset 0x10 clears it, and writing bit 0 as 0 leaves it. When a trigger condition and a clear fall in the same cycle, the trigger wins.
- R9: Bits [1:0] at offset 0x0C set the trigger type of source 0: 0 is high level (the reset default), 1 is rising edge, 2 is low level and 3 is falling edge. The other bits read 0.
- R10: The protection register (offset 0x08) stores bit 0 only and reads 0 in every other bit. The base register stores all 32 bits.
- R11: A route bit of 0 sends the source to `irq_o`, and the normal pending register (0x10 group) shows it. A route bit of 1 sends it to `fiq_o`, and the fast pending register (0x20 group) shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 81 | Source inputs; bit 0 is the external event source |
| bus_addr | input | 8 | Byte address; an address with nonzero bits [1:0] does nothing and reads 0 |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A register write is visible in read-back after the clock edge that takes it. An input change reaches the pending bit, and through it both outputs and the vector, on the next edge. Enabling a source whose input is already high takes two edges, one for the enable and one for the sample. The bench drives every stimulus on the falling edge. It checks steady-state results after at least two rising edges. For R6 it makes two samples: one just after the input change, where the output must still be low, and one just after the following rising edge, where it must be high.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [3:0] {
    GRP_CTRL = 4'h0,
    GRP_IRQP = 4'h1,
    GRP_FIQP = 4'h2,
    GRP_SEL  = 4'h3,
    GRP_EN   = 4'h4,
    GRP_MSK  = 4'h5
  } grp_e;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } nmi_trig_e;

  // Bits of one bank that belong to an existing source.
  function automatic logic [WORD_W-1:0] bank_valid(input int bank, input int nsrc);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++)
      if (bank * WORD_W + i < nsrc) m[i] = 1'b1;
    return m;
  endfunction

  // Vector address: base plus four bytes per source number.
  function automatic logic [WORD_W-1:0] vec_addr(input logic [WORD_W-1:0] base,
                                                 input logic [WORD_W-1:0] idx);
    return base + (idx << 2);
  endfunction

endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID   = '1,
  parameter bit                HAS_NMI = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_en,
  input  logic              we_msk,
  input  logic              we_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] src,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] msk_o,
  output logic [WORD_W-1:0] sel_o,
  output logic [WORD_W-1:0] pend_o
);

  // Bit 0 of the first bank belongs to the latched event source.
  localparam logic [WORD_W-1:0] LVL_MASK = HAS_NMI ? (VALID & ~WORD_W'(1)) : VALID;

  logic [WORD_W-1:0] en_q, msk_q, sel_q, pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      msk_q  <= VALID;
      sel_q  <= '0;
      pend_q <= '0;
    end else begin
      if (we_en)  en_q  <= wdata & VALID;
      if (we_msk) msk_q <= wdata & VALID;
      if (we_sel) sel_q <= wdata & VALID;
      pend_q <= src & en_q & LVL_MASK;
    end
  end

  assign en_o   = en_q;
  assign msk_o  = msk_q;
  assign sel_o  = sel_q;
  assign pend_o = pend_q;

  // R4: a level source can only be pending if it was enabled at the sampling edge
  a_r4_pend_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(en_q)) == '0);

endmodule

// File: rtl/intc_nmi.sv
module intc_nmi
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src,
  input  logic      enable,
  input  nmi_trig_e trig,
  input  logic      clr,
  output logic      pend_o
);

  logic prev_q, pend_q;
  logic hit_w;
  logic set_w;

  always_comb begin
    unique case (trig)
      TRIG_HIGH: hit_w = src;
      TRIG_RISE: hit_w = src & ~prev_q;
      TRIG_LOW:  hit_w = ~src;
      TRIG_FALL: hit_w = ~src & prev_q;
      default:   hit_w = 1'b0;
    endcase
  end

  assign set_w = enable & hit_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= src;
      if (set_w)    pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R8: the latched bit holds until software clears it
  a_r8_nmi_latched: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr |=> pend_q);

  // R8: a clear with no new event empties the latch
  a_r8_nmi_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && clr && !set_w |=> !pend_q);

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N     = 96,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R7: the reported index is requesting and nothing below it is
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req[idx_o] && ((req & ~({N{1'b1}} << idx_o)) == '0));

endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 81
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int NUM_BANKS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int TOT       = NUM_BANKS * WORD_W;
  localparam int IDX_W     = $clog2(TOT);

  logic [3:0] grp;
  logic [1:0] bank;
  logic       addr_ok, wr_ok;

  assign grp     = bus_addr[7:4];
  assign bank    = bus_addr[3:2];
  assign addr_ok = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && addr_ok;

  logic [TOT-1:0] src_ext, en_all, msk_all, sel_all, lvl_pend, pend_all;
  logic [TOT-1:0] elig_irq, elig_fiq;

  assign src_ext = TOT'(src_i);

  // ---------------- banks ----------------
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic we_en_w, we_msk_w, we_sel_w;
    assign we_en_w  = wr_ok && (grp == GRP_EN)  && (bank == 2'(b));
    assign we_msk_w = wr_ok && (grp == GRP_MSK) && (bank == 2'(b));
    assign we_sel_w = wr_ok && (grp == GRP_SEL) && (bank == 2'(b));

    intc_bank #(
      .VALID  (bank_valid(b, NUM_SRC)),
      .HAS_NMI(b == 0)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we_en (we_en_w),
      .we_msk(we_msk_w),
      .we_sel(we_sel_w),
      .wdata (bus_wdata),
      .src   (src_ext[b*WORD_W +: WORD_W]),
      .en_o  (en_all[b*WORD_W +: WORD_W]),
      .msk_o (msk_all[b*WORD_W +: WORD_W]),
      .sel_o (sel_all[b*WORD_W +: WORD_W]),
      .pend_o(lvl_pend[b*WORD_W +: WORD_W])
    );
  end

  // ---------------- control registers ----------------
  logic [WORD_W-1:0] base_q;
  logic              prot_q;
  nmi_trig_e         trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      prot_q <= 1'b0;
      trig_q <= TRIG_HIGH;
    end else if (wr_ok && grp == GRP_CTRL) begin
      case (bank)
        2'd1: base_q <= bus_wdata;
        2'd2: prot_q <= bus_wdata[0];
        2'd3: trig_q <= nmi_trig_e'(bus_wdata[1:0]);
        default: ;
      endcase
    end
  end

  // ---------------- external event source ----------------
  logic nmi_clr, nmi_pend;
  assign nmi_clr = wr_ok && (grp == GRP_IRQP) && (bank == 2'd0) && bus_wdata[0];

  intc_nmi u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src_ext[0]),
    .enable(en_all[0]),
    .trig  (trig_q),
    .clr   (nmi_clr),
    .pend_o(nmi_pend)
  );

  assign pend_all = lvl_pend | TOT'(nmi_pend);

  // ---------------- gating and outputs ----------------
  assign elig_irq = pend_all & en_all & ~msk_all & ~sel_all;
  assign elig_fiq = pend_all & en_all & ~msk_all &  sel_all;

  assign irq_o = |elig_irq;
  assign fiq_o = |elig_fiq;

  logic             prio_any;
  logic [IDX_W-1:0] prio_idx;

  intc_prio #(.N(TOT), .IDX_W(IDX_W)) u_prio (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (elig_irq),
    .any_o(prio_any),
    .idx_o(prio_idx)
  );

  logic [WORD_W-1:0] vector_w;
  assign vector_w = vec_addr(base_q, WORD_W'(prio_idx));

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      case (grp)
        GRP_CTRL: begin
          case (bank)
            2'd0: bus_rdata = vector_w;
            2'd1: bus_rdata = base_q;
            2'd2: bus_rdata = WORD_W'(prot_q);
            default: bus_rdata = WORD_W'(trig_q);
          endcase
        end
        default: begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == 2'(b)) begin
              case (grp)
                GRP_IRQP: bus_rdata = pend_all[b*WORD_W +: WORD_W] & ~sel_all[b*WORD_W +: WORD_W];
                GRP_FIQP: bus_rdata = pend_all[b*WORD_W +: WORD_W] &  sel_all[b*WORD_W +: WORD_W];
                GRP_SEL:  bus_rdata = sel_all[b*WORD_W +: WORD_W];
                GRP_EN:   bus_rdata = en_all[b*WORD_W +: WORD_W];
                GRP_MSK:  bus_rdata = msk_all[b*WORD_W +: WORD_W];
                default:  bus_rdata = '0;
              endcase
            end
          end
        end
      endcase
    end
  end

  // R1: no request is raised in the first cycle out of reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o && !fiq_o);

  // R5: the normal request line agrees with the priority search
  a_r5_irq_agrees_prio: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == prio_any);

endmodule

// File: tb/banked_intc_test.sv
module banked_intc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [80:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  banked_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // bench model of the programmed state
  logic [95:0] m_en, m_msk, m_sel;
  logic [31:0] m_base;

  function automatic logic [31:0] vbank(input int b);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (b * 32 + i < 81) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [95:0] exp_pend();
    return {15'b0, src} & m_en;
  endfunction

  function automatic logic [95:0] elig(input bit fast);
    logic [95:0] p = exp_pend() & ~m_msk;
    return fast ? (p & m_sel) : (p & ~m_sel);
  endfunction

  function automatic logic [31:0] exp_vec();
    logic [95:0] e = elig(1'b0);
    for (int i = 0; i < 96; i++) if (e[i]) return m_base + 32'(i) * 4;
    return m_base;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_bank(input int grp, input int b, input logic [31:0] d);
    wr_reg(8'(grp * 16 + b * 4), d);
    if (grp == 4) m_en[b*32 +: 32]  = d & vbank(b);
    if (grp == 5) m_msk[b*32 +: 32] = d & vbank(b);
    if (grp == 3) m_sel[b*32 +: 32] = d & vbank(b);
  endtask

  task automatic clear_all();
    for (int b = 0; b < 3; b++) begin
      set_bank(4, b, 32'h0);
      set_bank(5, b, 32'hFFFF_FFFF);
      set_bank(3, b, 32'h0);
    end
    settle(2);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned seed_init;
    seed_init = $urandom(32'd1234);
    m_en = '0; m_sel = '0; m_base = '0;
    m_msk = {vbank(2), vbank(1), vbank(0)};

    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    rd_reg(8'h00, d); chk("R1 vector", d, 0);
    for (int b = 0; b < 3; b++) begin
      rd_reg(8'(8'h40 + b * 4), d); chk("R1 enable", d, 0);
      rd_reg(8'(8'h50 + b * 4), d); chk("R1 mask", d, vbank(b));
      rd_reg(8'(8'h10 + b * 4), d); chk("R1 pending", d, 0);
    end
    rd_reg(8'h0C, d); chk("R9 trigger default", d, 0);

    // R10 control registers
    wr_reg(8'h04, 32'hDEAD_BEEC); rd_reg(8'h04, d); chk("R10 base", d, 32'hDEAD_BEEC);
    wr_reg(8'h08, 32'hFFFF_FFFF); rd_reg(8'h08, d); chk("R10 protection", d, 1);
    wr_reg(8'h0C, 32'hFFFF_FFFF); rd_reg(8'h0C, d); chk("R9 trigger field", d, 3);
    wr_reg(8'h0C, 32'h0);
    wr_reg(8'h04, 32'h0000_1000); m_base = 32'h1000;

    // R3 nonexistent sources
    wr_reg(8'h48, 32'hFFFF_FFFF); rd_reg(8'h48, d); chk("R3 enable bank 2", d, 32'h0001_FFFF);
    wr_reg(8'h38, 32'hFFFF_FFFF); rd_reg(8'h38, d); chk("R3 route bank 2", d, 32'h0001_FFFF);
    clear_all();

    // R2 / R6 source 37 -> bank 1 bit 5
    set_bank(4, 1, 32'h20);
    set_bank(5, 1, ~32'h20);
    rd_reg(8'h44, d); chk("R2 enable readback", d, 32'h20);
    settle(2);
    @(negedge clk);
    src[37] = 1'b1;
    #1 chk("R6 before edge", 32'(irq), 0);
    @(posedge clk);
    #1 chk("R6 after edge", 32'(irq), 1);
    settle(1);
    rd_reg(8'h14, d); chk("R2 pending bank 1 bit 5", d, 32'h20);
    chk("R11 fiq idle", 32'(fiq), 0);

    // R4 pending ignores writes and follows level
    wr_reg(8'h14, 32'h0); settle(1);
    rd_reg(8'h14, d); chk("R4 write 0 ignored", d, 32'h20);
    src[37] = 1'b0; settle(2);
    rd_reg(8'h14, d); chk("R4 follows level", d, 0);
    chk("R4 irq drops", 32'(irq), 0);
    wr_reg(8'h14, 32'hFFFF_FFFF); settle(1);
    rd_reg(8'h14, d); chk("R4 write 1 ignored", d, 0);
    set_bank(4, 1, 32'h0); src[37] = 1'b1; settle(2);
    rd_reg(8'h14, d); chk("R4 disabled never pends", d, 0);

    // R11 routing, R5 masking
    set_bank(3, 1, 32'h20); set_bank(4, 1, 32'h20); settle(2);
    chk("R11 fiq set", 32'(fiq), 1);
    chk("R11 irq clear", 32'(irq), 0);
    rd_reg(8'h24, d); chk("R11 fast pending", d, 32'h20);
    rd_reg(8'h14, d); chk("R11 normal pending", d, 0);
    set_bank(5, 1, 32'hFFFF_FFFF); settle(2);
    chk("R5 masked fiq", 32'(fiq), 0);
    rd_reg(8'h24, d); chk("R5 pending kept", d, 32'h20);
    src[37] = 1'b0;
    clear_all();

    // R7 vector
    set_bank(4, 1, 32'h100); set_bank(5, 1, ~32'h100);
    set_bank(4, 2, 32'h40);  set_bank(5, 2, ~32'h40);
    src[40] = 1'b1; src[70] = 1'b1; settle(2);
    rd_reg(8'h00, d); chk("R7 lowest 40", d, 32'h1000 + 160);
    set_bank(5, 1, 32'hFFFF_FFFF); settle(1);
    rd_reg(8'h00, d); chk("R7 next 70", d, 32'h1000 + 280);
    src[70] = 1'b0; settle(2);
    rd_reg(8'h00, d); chk("R7 none", d, 32'h1000);
    src[40] = 1'b0;
    clear_all();

    // R8 / R9 external event source
    set_bank(4, 0, 32'h1); set_bank(5, 0, 32'hFFFF_FFFE);
    src[0] = 1'b1; settle(2);
    rd_reg(8'h10, d); chk("R9 high level sets", d, 1);
    chk("R8 irq", 32'(irq), 1);
    rd_reg(8'h00, d); chk("R7 source 0 vector", d, 32'h1000);
    wr_reg(8'h10, 32'h1); settle(1);
    rd_reg(8'h10, d); chk("R8 set wins over clear", d, 1);
    src[0] = 1'b0; settle(2);
    rd_reg(8'h10, d); chk("R8 latched after input low", d, 1);
    wr_reg(8'h10, 32'hFFFF_FFFE); settle(1);
    rd_reg(8'h10, d); chk("R8 write 0 no effect", d, 1);
    wr_reg(8'h10, 32'h1); settle(1);
    rd_reg(8'h10, d); chk("R8 cleared", d, 0);
    chk("R8 irq cleared", 32'(irq), 0);

    wr_reg(8'h0C, 32'h1); settle(1);
    src[0] = 1'b1; settle(2);
    rd_reg(8'h10, d); chk("R9 rising sets", d, 1);
    wr_reg(8'h10, 32'h1); settle(2);
    rd_reg(8'h10, d); chk("R9 rising no reset while high", d, 0);

    wr_reg(8'h0C, 32'h3); settle(1);
    src[0] = 1'b0; settle(2);
    rd_reg(8'h10, d); chk("R9 falling sets", d, 1);
    wr_reg(8'h10, 32'h1); settle(2);
    rd_reg(8'h10, d); chk("R9 falling cleared", d, 0);

    wr_reg(8'h0C, 32'h2); settle(2);
    rd_reg(8'h10, d); chk("R9 low level sets", d, 1);
    src[0] = 1'b1; settle(1);
    wr_reg(8'h10, 32'h1); settle(1);
    rd_reg(8'h10, d); chk("R9 low level cleared when high", d, 0);
    wr_reg(8'h0C, 32'h0); src[0] = 1'b0;
    clear_all();
    wr_reg(8'h10, 32'h1); settle(1);

    // R5 / R7 / R11 random
    for (int it = 0; it < 80; it++) begin
      int kind = int'($urandom % 4);
      int b = int'($urandom % 3);
      logic [31:0] r = $urandom;
      if (kind == 3) begin
        src = {17'($urandom), $urandom, $urandom};
        src[0] = 1'b0;
      end else begin
        if (kind == 0 && b == 0) r[0] = 1'b0;
        set_bank(kind == 0 ? 4 : (kind == 1 ? 5 : 3), b, r);
      end
      settle(3);
      chk("R5 irq random", 32'(irq), 32'(|elig(1'b0)));
      chk("R11 fiq random", 32'(fiq), 32'(|elig(1'b1)));
      rd_reg(8'h00, d); chk("R7 vector random", d, exp_vec());
      rd_reg(8'(8'h10 + b * 4), d);
      chk("R11 normal pending random", d, exp_pend()[b*32 +: 32] & ~m_sel[b*32 +: 32]);
      rd_reg(8'(8'h20 + b * 4), d);
      chk("R11 fast pending random", d, exp_pend()[b*32 +: 32] & m_sel[b*32 +: 32]);
    end

    summary();
    $finish;
  end

endmodule